// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block turns the already-synchronized values of an 8-line general purpose port into interrupt requests. Each line is configured independently to fire on a high level, a low level, a rising edge, a falling edge, or any transition. Edge events are held in a per-line status bit until software writes a one to the matching bit of a clear register. Level conditions are not held: their status bit tracks the pin and drops by itself once the active level is gone.

A simple strobe-style register port gives software access to the four configuration registers and the raw and enabled (masked) status views. The OR of all enabled status bits drives one registered interrupt line toward a parent interrupt controller. A handler reads the masked view to find the lines that need service, then clears the edge lines it has handled.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the mode-select (0x404), any-edge (0x408), polarity (0x40C) and enable (0x410) registers all read zero. Each register is NLINES bits wide, with bit n belonging to line n. A write is visible on a later read. Read data appears on bus_rdata one cycle after a read strobe (bus_sel=1, bus_wr=0).
- R2: When mode-select bit n is 1, raw status bit n equals 1 exactly when line n equals polarity bit n (1 = high active, 0 = low active), one cycle after the line value is presented. It holds nothing, and a clear write has no effect on it.
- R3: When mode-select bit n and any-edge bit n are both 0, status bit n is set one cycle after a 0-to-1 transition (polarity bit 1) or a 1-to-0 transition (polarity bit 0). It then stays set.
- R4: When mode-select bit n is 0 and any-edge bit n is 1, either transition on line n sets status bit n, whatever the polarity bit holds.
- R5: Writing the clear register (0x41C) clears the edge-mode status bits written as 1 and leaves the bits written as 0 untouched. The clear register reads zero.
- R6: When a qualifying edge and a clear for the same line fall in the same cycle, the status bit ends up set.
- R7: Raw status is read at 0x414. Masked status, read at 0x418, equals raw status AND the enable register.
- R8: irq_o is high exactly one cycle after any bit of the masked status is high.
- R9: After reset all status bits are zero and irq_o is low. A line that holds its value sets no edge status, because edges are found by comparing each cycle's value with the previous cycle's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | NLINES | Synchronized line values |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Eight lines are configured across every mode at the same time: two level polarities, both single-edge directions, and any-edge with each polarity value. Hundreds of input patterns are then swept while a model works out every line's status. One any-edge line has its polarity bit set on purpose, so a design that lets polarity leak into any-edge mode misses transitions on it. Clear writes land on the same cycles as fresh edges and on level lines. A design that lets the clear win would lose an event, and one that latches level status would keep reporting after the pin releases. The enable register is changed in the middle of the sweep and then zeroed, so a masked view or irq_o that ignores the enable shows up as a mismatch.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_EVENT  = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h41C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SENSE,
    SEL_BOTH,
    SEL_EVENT,
    SEL_ENABLE,
    SEL_RAW,
    SEL_MASKED,
    SEL_CLEAR
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_SENSE:  return SEL_SENSE;
      OFS_BOTH:   return SEL_BOTH;
      OFS_EVENT:  return SEL_EVENT;
      OFS_ENABLE: return SEL_ENABLE;
      OFS_RAW:    return SEL_RAW;
      OFS_MASKED: return SEL_MASKED;
      OFS_CLEAR:  return SEL_CLEAR;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NLINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  input  logic [NLINES-1:0] raw_st,
  output logic [NLINES-1:0] cfg_sense,
  output logic [NLINES-1:0] cfg_both,
  output logic [NLINES-1:0] cfg_event,
  output logic [NLINES-1:0] cfg_enable,
  output logic [NLINES-1:0] clr_mask,
  output logic [NLINES-1:0] bus_rdata
);

  reg_sel_e          sel;
  logic              wr_en;
  logic              rd_en;
  logic [NLINES-1:0] rd_mux;

  assign sel   = decode_addr(bus_addr);
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  // a clear strobe lasts exactly the cycle of the write
  assign clr_mask = (wr_en && sel == SEL_CLEAR) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_sense  <= '0;
      cfg_both   <= '0;
      cfg_event  <= '0;
      cfg_enable <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_SENSE:  cfg_sense  <= bus_wdata;
        SEL_BOTH:   cfg_both   <= bus_wdata;
        SEL_EVENT:  cfg_event  <= bus_wdata;
        SEL_ENABLE: cfg_enable <= bus_wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_SENSE:  rd_mux = cfg_sense;
      SEL_BOTH:   rd_mux = cfg_both;
      SEL_EVENT:  rd_mux = cfg_event;
      SEL_ENABLE: rd_mux = cfg_enable;
      SEL_RAW:    rd_mux = raw_st;
      SEL_MASKED: rd_mux = raw_st & cfg_enable;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line (
  input  logic clk,
  input  logic rst,
  input  logic line_now,
  input  logic sense_lvl,
  input  logic any_edge,
  input  logic polarity,
  input  logic clr,
  output logic line_prev,
  output logic status
);

  logic rise;
  logic fall;
  logic hit;
  logic status_nx;

  assign rise = line_now & ~line_prev;
  assign fall = ~line_now & line_prev;

  always_comb begin
    if (any_edge) hit = rise | fall;
    else if (polarity) hit = rise;
    else hit = fall;
  end

  // level status is recomputed each cycle; edge status latches, new edge beats clear
  always_comb begin
    if (sense_lvl) status_nx = ~(line_now ^ polarity);
    else status_nx = hit | (status & ~clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_prev <= 1'b0;
      status    <= 1'b0;
    end else begin
      line_prev <= line_now;
      status    <= status_nx;
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NLINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] line_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  output logic              irq_o
);

  logic [NLINES-1:0] cfg_sense;
  logic [NLINES-1:0] cfg_both;
  logic [NLINES-1:0] cfg_event;
  logic [NLINES-1:0] cfg_enable;
  logic [NLINES-1:0] clr_mask;
  logic [NLINES-1:0] raw_st;
  logic [NLINES-1:0] line_prev;
  logic              irq_q;

  gpio_irq_regs #(.NLINES(NLINES)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .raw_st     (raw_st),
    .cfg_sense  (cfg_sense),
    .cfg_both   (cfg_both),
    .cfg_event  (cfg_event),
    .cfg_enable (cfg_enable),
    .clr_mask   (clr_mask),
    .bus_rdata  (bus_rdata)
  );

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    gpio_irq_line u_line (
      .clk       (clk),
      .rst       (rst),
      .line_now  (line_i[n]),
      .sense_lvl (cfg_sense[n]),
      .any_edge  (cfg_both[n]),
      .polarity  (cfg_event[n]),
      .clr       (clr_mask[n]),
      .line_prev (line_prev[n]),
      .status    (raw_st[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else irq_q <= |(raw_st & cfg_enable);
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NLINES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] line_i,
  input logic [NLINES-1:0] line_prev,
  input logic [NLINES-1:0] st,
  input logic [NLINES-1:0] sense,
  input logic [NLINES-1:0] ev,
  input logic [NLINES-1:0] en,
  input logic [NLINES-1:0] clr_mask,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NLINES-1:0] bus_rdata,
  input logic              irq_o
);

  a_r2_level_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((st ^ ~($past(line_i) ^ $past(ev))) & $past(sense)) == '0));

  a_r5_edge_holds: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(st) & ~$past(sense) & ~$past(clr_mask) & ~st) == '0));

  a_r9_no_edge_no_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st & ~$past(st) & ~$past(sense) &
               ~($past(line_i) ^ $past(line_prev))) == '0));

  a_r8_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(st & en)) |=> irq_o);

  a_r8_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(st & en)) |=> !irq_o);

  a_r5_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == OFS_CLEAR) |=> (bus_rdata == '0));

endmodule

bind gpio_irq_detect gpio_irq_chk #(.NLINES(NLINES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .line_i    (line_i),
  .line_prev (line_prev),
  .st        (raw_st),
  .sense     (cfg_sense),
  .ev        (cfg_event),
  .en        (cfg_enable),
  .clr_mask  (clr_mask),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;

  localparam int N = 8;
  localparam logic [11:0] A_SENSE  = 12'h404;
  localparam logic [11:0] A_BOTH   = 12'h408;
  localparam logic [11:0] A_EVENT  = 12'h40C;
  localparam logic [11:0] A_ENABLE = 12'h410;
  localparam logic [11:0] A_RAW    = 12'h414;
  localparam logic [11:0] A_MASKED = 12'h418;
  localparam logic [11:0] A_CLEAR  = 12'h41C;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] line_i = '0;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] m_sense = '0, m_both = '0, m_ev = '0, m_en = '0;
  logic [N-1:0] m_st = '0, m_cur = '0;

  gpio_irq_detect #(.NLINES(N)) u_dut (
    .clk(clk), .rst(rst), .line_i(line_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  task automatic check_val(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [N-1:0] edge_hits(input logic [N-1:0] prv, input logic [N-1:0] now);
    logic [N-1:0] r, f;
    r = now & ~prv;
    f = ~now & prv;
    return (m_both & (r | f)) | (~m_both & m_ev & r) | (~m_both & ~m_ev & f);
  endfunction

  // apply a new line value, optionally with a clear in the same cycle
  task automatic step(input logic [N-1:0] v, input logic [N-1:0] clr, input bit do_clr);
    logic [N-1:0] h;
    @(negedge clk);
    line_i = v;
    if (do_clr) begin
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CLEAR; bus_wdata = clr;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end
    h = edge_hits(m_cur, v);
    m_st = (m_sense & ~(v ^ m_ev)) | (~m_sense & (h | (m_st & ~(do_clr ? clr : '0))));
    m_cur = v;
  endtask

  function automatic string tag_of(input int n);
    if (m_sense[n]) return "R2 level status";
    if (m_both[n]) return "R4 any-edge status";
    return "R3 single-edge status";
  endfunction

  task automatic verify_status(input string ctx);
    logic [N-1:0] d;
    rd(A_RAW, d);
    checks++;
    if (irq_o !== (|(m_st & m_en))) begin
      errors++;
      $display("FAIL R8 irq %s actual=%0b expected=%0b", ctx, irq_o, |(m_st & m_en));
    end
    for (int n = 0; n < N; n++) begin
      checks++;
      if (d[n] !== m_st[n]) begin
        errors++;
        $display("FAIL %s line %0d (%s) actual=%0b expected=%0b", tag_of(n), n, ctx, d[n], m_st[n]);
      end
    end
    rd(A_MASKED, d);
    check_val({"R7 masked ", ctx}, d, m_st & m_en);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [N-1:0] d;
    logic [N-1:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (irq_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 irq after reset actual=%0b expected=0", irq_o);
    end
    rd(A_RAW, d);    check_val("R9 raw after reset", d, '0);
    rd(A_MASKED, d); check_val("R9 masked after reset", d, '0);
    rd(A_SENSE, d);  check_val("R1 sense reset", d, '0);
    rd(A_BOTH, d);   check_val("R1 any-edge reset", d, '0);
    rd(A_EVENT, d);  check_val("R1 polarity reset", d, '0);
    rd(A_ENABLE, d); check_val("R1 enable reset", d, '0);

    // lines: 0 high lvl, 1 low lvl, 2 rise, 3 fall, 4 any, 5 any (polarity set), 6 rise, 7 fall
    m_sense = 8'h03; m_both = 8'h30; m_ev = 8'h65; m_en = 8'hFF;
    wr(A_SENSE, m_sense);
    wr(A_BOTH, m_both);
    wr(A_EVENT, m_ev);
    wr(A_ENABLE, m_en);
    wr(A_CLEAR, 8'hFF);
    m_st = m_sense & ~(m_cur ^ m_ev);
    rd(A_SENSE, d);  check_val("R1 sense readback", d, m_sense);
    rd(A_BOTH, d);   check_val("R1 any-edge readback", d, m_both);
    rd(A_EVENT, d);  check_val("R1 polarity readback", d, m_ev);
    rd(A_ENABLE, d); check_val("R1 enable readback", d, m_en);
    rd(A_CLEAR, d);  check_val("R5 clear reads zero", d, '0);
    verify_status("after config");

    // directed: rise on line 2, then fall keeps it (R3), zero clear ignored, one clear works (R5)
    step(8'h04, '0, 1'b0); verify_status("R3 rise");
    step(8'h00, '0, 1'b0); verify_status("R3 held");
    step(8'h00, 8'h00, 1'b1); verify_status("R5 zero clear");
    step(8'h00, 8'h04, 1'b1); verify_status("R5 clear");
    // same-cycle edge and clear on line 2 (R6)
    step(8'h04, 8'h04, 1'b1); verify_status("R6 edge beats clear");
    check_val("R6 line2 stays set", m_st & 8'h04, 8'h04);
    // clear aimed at level lines has no effect (R2)
    step(8'h05, 8'h03, 1'b1); verify_status("R2 clear on level");
    // steady input sets no edge (R9)
    step(8'h00, 8'hFC, 1'b1);
    step(8'h00, '0, 1'b0); verify_status("R9 steady");

    for (int i = 0; i < 300; i++) begin
      v = 8'((i * 73) + (i >> 2) + 11);
      if (i == 150) begin
        m_en = 8'h5A;
        wr(A_ENABLE, m_en);
      end
      if (i % 5 == 0) step(v, 8'((i * 29) ^ v), 1'b1);
      else step(v, '0, 1'b0);
      if (i % 7 == 3) step(v, '0, 1'b0);
      verify_status("sweep");
    end

    m_en = '0;
    wr(A_ENABLE, m_en);
    verify_status("R8 all disabled");
    summary();
  end

endmodule